// File: doc/BRIEF.md
# Three-State Multi-Cycle 16-bit Processor Core

This core executes a program of 16-bit instructions. Each instruction passes through the same three states in a fixed order: fetch, decode and execute. The core holds a program counter, an instruction register and a register file of sixteen 16-bit registers. It contains two separate arrays, an instruction store and a data store, each of 256 words. Both arrays are written through a single preload port, normally while the core is held in reset.

The upper four bits of each instruction are the opcode. Bits [11:8] name the target register in every format. Four operations are defined:

- add two registers;
- load a register from a direct data address;
- store a register to a direct data address;
- load a zero-extended 8-bit constant.

Every other opcode does nothing for its three cycles.

The state, program counter and instruction register are visible on ports. A combinational peek port reads any register, so results can be observed from outside.

Top module: `mc_cpu16`

## Requirements
- R1: After reset the state output repeats fetch (0), decode (1), execute (2) in that order, one state per clock cycle, so every instruction takes exactly three cycles.
- R2: The instruction register takes the word at the program counter address at the end of fetch. The program counter shows its old value plus one from decode onward. Neither changes during decode or execute.
- R3: Opcode 2 writes Rd = Rs + Rt, with Rd in bits [11:8], Rs in bits [7:4] and Rt in bits [3:0]. Example: 2214h gives R2 = R1 + R4.
- R4: The addition wraps modulo 2^16 and raises no flag.
- R5: Opcode 0 loads Rd (bits [11:8]) from the data word at the direct address in bits [7:0]. Example: 0308h gives R3 = D[8].
- R6: Opcode 1 writes the register in bits [11:8] to the data word at the address in bits [7:0]. It changes no register.
- R7: Opcode 3 writes the 8-bit constant in bits [7:0], zero-extended, into the register in bits [11:8].
- R8: Any opcode other than 0 to 3 leaves all registers and data words unchanged and still takes three cycles.
- R9: A register result is written at the end of execute. During execute the peek port still shows the old value, and the new value appears in the fetch cycle that follows.
- R10: While reset is asserted, the state is fetch (0), the program counter is 0, the instruction register is 0 and all registers read 0.
- R11: The peek port returns the current contents of the register it addresses, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_en_i | input | 1 | Preload write strobe |
| ld_sel_i | input | 1 | Preload target: 0 = instruction store, 1 = data store |
| ld_addr_i | input | 8 | Preload word address |
| ld_data_i | input | 16 | Preload word |
| rf_peek_addr_i | input | 4 | Register to observe |
| rf_peek_data_o | output | 16 | Contents of the observed register |
| state_o | output | 2 | Current state: 0 = fetch, 1 = decode, 2 = execute |
| pc_o | output | 8 | Program counter |
| ir_o | output | 16 | Instruction register |

## Verification
After reset is released, the first rising edge moves the core into decode. From that point the program counter and instruction register are due one cycle after each fetch, and a register result is due in the fetch cycle after execute, three cycles after the instruction was fetched. The scoreboard monitor samples on the falling edge and keeps the same three-cycle rhythm. In decode it checks the program counter and instruction register. In execute it checks that the target register still holds its old value. In the following fetch it checks the new value.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2
  } state_e;

  localparam logic [3:0] OP_LOAD  = 4'h0;
  localparam logic [3:0] OP_STORE = 4'h1;
  localparam logic [3:0] OP_ADD   = 4'h2;
  localparam logic [3:0] OP_IMM   = 4'h3;
endpackage

// File: rtl/mc_mem.sv
module mc_mem #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int Depth = 1 << AW;

  logic [DW-1:0] mem_q [Depth];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read is registered by the consumer (IR or data latch)
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int DW  = 16,
  parameter int RA  = 4,
  parameter int NRD = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [RA-1:0]           waddr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [NRD-1:0][RA-1:0]  raddr_i,
  output logic [NRD-1:0][DW-1:0]  rdata_o
);
  localparam int NReg = 1 << RA;

  logic [DW-1:0] rf_q [NReg];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NReg; i++) rf_q[i] <= '0;
    end else if (we_i) begin
      rf_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = rf_q[raddr_i[g]];
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
#(
  parameter int PW = 8,
  parameter int IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] imem_rdata_i,
  output state_e        state_o,
  output logic [PW-1:0] pc_o,
  output logic [IW-1:0] ir_o
);
  state_e        st_q;
  logic [PW-1:0] pc_q;
  logic [IW-1:0] ir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_FETCH;
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      unique case (st_q)
        ST_FETCH: begin
          ir_q <= imem_rdata_i;
          pc_q <= pc_q + 1'b1;
          st_q <= ST_DECODE;
        end
        ST_DECODE: st_q <= ST_EXEC;
        default:   st_q <= ST_FETCH;
      endcase
    end
  end

  assign state_o = st_q;
  assign pc_o    = pc_q;
  assign ir_o    = ir_q;

  p_seq_fd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_FETCH |=> st_q == ST_DECODE);
  p_seq_de_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_DECODE |=> st_q == ST_EXEC);
  p_seq_ef_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_EXEC |=> st_q == ST_FETCH);
  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_FETCH |=> pc_q == $past(pc_q) + 1'b1);
  p_ir_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != ST_FETCH |=> $stable(ir_q) && $stable(pc_q));
endmodule

// File: rtl/mc_cpu16.sv
module mc_cpu16
  import mc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int PW = 8,
  parameter int RA = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_en_i,
  input  logic          ld_sel_i,
  input  logic [7:0]    ld_addr_i,
  input  logic [15:0]   ld_data_i,
  input  logic [3:0]    rf_peek_addr_i,
  output logic [15:0]   rf_peek_data_o,
  output logic [1:0]    state_o,
  output logic [7:0]    pc_o,
  output logic [15:0]   ir_o
);
  localparam int IW  = 16;
  localparam int NRD = 4;

  state_e        st;
  logic [PW-1:0] pc;
  logic [IW-1:0] ir;
  logic [IW-1:0] imem_rdata;

  logic [3:0]    opc;
  logic [RA-1:0] f_rd, f_rs, f_rt;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_imm;

  assign opc    = ir[15:12];
  assign f_rd   = ir[11:8];
  assign f_rs   = ir[7:4];
  assign f_rt   = ir[3:0];
  assign f_addr = ir[AW-1:0];
  assign f_imm  = {{(DW-8){1'b0}}, ir[7:0]};

  mc_mem #(.DW(IW), .AW(PW)) u_imem (
    .clk_i   (clk_i),
    .we_i    (ld_en_i && !ld_sel_i),
    .waddr_i (ld_addr_i),
    .wdata_i (ld_data_i),
    .raddr_i (pc),
    .rdata_o (imem_rdata)
  );

  mc_ctrl #(.PW(PW), .IW(IW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .imem_rdata_i (imem_rdata),
    .state_o      (st),
    .pc_o         (pc),
    .ir_o         (ir)
  );

  // register file: 0 = Rs, 1 = Rt, 2 = Rd, 3 = peek
  logic [NRD-1:0][RA-1:0] rf_ra;
  logic [NRD-1:0][DW-1:0] rf_rd;
  logic                   rf_we;
  logic [DW-1:0]          rf_wdata;

  assign rf_ra = {rf_peek_addr_i, f_rd, f_rt, f_rs};

  mc_regfile #(.DW(DW), .RA(RA), .NRD(NRD)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (f_rd),
    .wdata_i (rf_wdata),
    .raddr_i (rf_ra),
    .rdata_o (rf_rd)
  );

  // operand latches filled in decode
  logic [DW-1:0] a_q, b_q, s_q, md_q;
  logic [DW-1:0] dmem_rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q  <= '0;
      b_q  <= '0;
      s_q  <= '0;
      md_q <= '0;
    end else if (st == ST_DECODE) begin
      a_q  <= rf_rd[0];
      b_q  <= rf_rd[1];
      s_q  <= rf_rd[2];
      md_q <= dmem_rdata;
    end
  end

  always_comb begin
    rf_we    = 1'b0;
    rf_wdata = '0;
    if (st == ST_EXEC) begin
      unique case (opc)
        OP_LOAD: begin rf_we = 1'b1; rf_wdata = md_q;      end
        OP_ADD:  begin rf_we = 1'b1; rf_wdata = a_q + b_q; end
        OP_IMM:  begin rf_we = 1'b1; rf_wdata = f_imm;     end
        default: ;
      endcase
    end
  end

  logic          dm_we;
  logic [AW-1:0] dm_waddr;
  logic [DW-1:0] dm_wdata;
  logic          core_st;

  assign core_st  = (st == ST_EXEC) && (opc == OP_STORE);
  assign dm_we    = core_st || (ld_en_i && ld_sel_i);
  assign dm_waddr = core_st ? f_addr : ld_addr_i[AW-1:0];
  assign dm_wdata = core_st ? s_q : ld_data_i[DW-1:0];

  mc_mem #(.DW(DW), .AW(AW)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (dm_we),
    .waddr_i (dm_waddr),
    .wdata_i (dm_wdata),
    .raddr_i (f_addr),
    .rdata_o (dmem_rdata)
  );

  assign rf_peek_data_o = rf_rd[3];
  assign state_o        = st;
  assign pc_o           = pc;
  assign ir_o           = ir;

  // Rd read port reflects the written value in the next fetch
  p_add_wb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_EXEC && opc == OP_ADD) |=> rf_rd[2] == $past(a_q + b_q));
  p_imm_wb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_EXEC && opc == OP_IMM) |=> rf_rd[2] == {{(DW-8){1'b0}}, $past(ir[7:0])});
  p_noop_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_EXEC && opc > OP_IMM) |=> $stable(rf_rd[2]));
  p_old_in_exec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == ST_DECODE |=> $stable(rf_rd[2]));
endmodule

// File: tb/mc_cpu16_tb_top.sv
module mc_cpu16_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_en = 1'b0, ld_sel = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [3:0]  peek_addr = '0;
  logic [15:0] peek_data;
  logic [1:0]  state;
  logic [7:0]  pc;
  logic [15:0] ir;

  always #4 clk = ~clk;

  mc_cpu16 dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ld_en_i(ld_en), .ld_sel_i(ld_sel),
    .ld_addr_i(ld_addr), .ld_data_i(ld_data), .rf_peek_addr_i(peek_addr),
    .rf_peek_data_o(peek_data), .state_o(state), .pc_o(pc), .ir_o(ir)
  );

  typedef struct {
    logic [7:0]  pc;
    logic [15:0] ir;
    logic [3:0]  rd;
    logic [15:0] oldv;
    logic [15:0] newv;
    string       req;
  } item_t;

  item_t       q[$];
  int          n_run = 0, n_fail = 0;
  logic [15:0] m_rf [16];
  logic [15:0] m_dm [256];
  logic [7:0]  m_pc = 0;
  bit          done = 0;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic preload(bit sel, logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // driver: models the instruction from the requirements, pushes expectation
  task automatic drive(logic [15:0] ins, string req);
    item_t it;
    logic [3:0] rd = ins[11:8];
    it.pc = m_pc + 8'd1; it.ir = ins; it.rd = rd; it.req = req;
    it.oldv = m_rf[rd];
    case (ins[15:12])
      4'h0: m_rf[rd] = m_dm[ins[7:0]];
      4'h1: m_dm[ins[7:0]] = m_rf[rd];
      4'h2: m_rf[rd] = m_rf[ins[7:4]] + m_rf[ins[3:0]];
      4'h3: m_rf[rd] = {8'h00, ins[7:0]};
      default: ;
    endcase
    it.newv = m_rf[rd];
    q.push_back(it);
    preload(1'b0, m_pc, ins);
    m_pc++;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_rf[i] = '0;
    for (int i = 0; i < 256; i++) m_dm[i] = '0;
    m_dm[8] = 16'h0007; m_dm[9] = 16'hFFFF;
    for (int i = 0; i < 64; i++) preload(1'b1, 8'(i), m_dm[i]);
    for (int i = 0; i < 32; i++) preload(1'b0, 8'(i), 16'hF000);
    drive(16'h3104, "R7");   // R1 = 4
    drive(16'h3405, "R7");   // R4 = 5
    drive(16'h2214, "R3");   // R2 = 9
    drive(16'h0308, "R5");   // R3 = D[8] = 7
    drive(16'h2223, "R3");   // R2 = 16
    drive(16'h1220, "R6");   // D[20h] = 16, no reg change
    drive(16'h0520, "R6");   // R5 = D[20h]
    drive(16'h36FF, "R7");   // R6 = 00FF
    drive(16'h0709, "R5");   // R7 = FFFF
    drive(16'h2877, "R4");   // R8 = FFFE wrap
    drive(16'h2971, "R4");   // R9 = 0003 wrap
    drive(16'hF600, "R8");   // no-op
    drive(16'h7A12, "R8");   // no-op
    drive(16'h1A21, "R6");   // D[21h] = 0
    drive(16'h0B08, "R8");   // R11 = 7: no-op above left D[8] alone
    // reset state checks
    @(negedge clk);
    chk("R10 state", 16'(state), 16'd0);
    chk("R10 pc", 16'(pc), 16'd0);
    chk("R10 ir", ir, 16'h0000);
    peek_addr = 4'd2;
    #1 chk("R10 reg", peek_data, 16'h0000);
    rst_ni = 1'b1;
  end

  // monitor: pops expectations in step with the three-cycle rhythm
  initial begin
    item_t it;
    @(posedge rst_ni);
    while (q.size() > 0) begin
      @(negedge clk);
      it = q.pop_front();
      chk("R1 decode", 16'(state), 16'd1);
      chk("R2 pc", 16'(pc), 16'(it.pc));
      chk("R2 ir", ir, it.ir);
      peek_addr = it.rd;
      @(negedge clk);
      chk("R1 exec", 16'(state), 16'd2);
      chk("R9 old value", peek_data, it.oldv);
      chk("R2 ir stable", ir, it.ir);
      @(negedge clk);
      chk("R1 fetch", 16'(state), 16'd0);
      chk({it.req, " result"}, peek_data, it.newv);
    end
    peek_addr = 4'd4;
    #1 chk("R11 peek", peek_data, 16'h0005);
    peek_addr = 4'd6;
    #1 chk("R11 peek", peek_data, 16'h00FF);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule